// File: doc/BRIEF.md
# UART Receiver with Status Flags

This block turns an asynchronous serial line into bytes that software collects over a small 8-bit register bus. The line is sampled at sixteen times the bit rate. A falling edge is confirmed as a start bit at the middle of that bit. Each data bit, the optional parity bit and the stop bit are then taken from their mid-bit samples, with the least significant data bit arriving first. A good character is placed in a one-deep data register and sets a full flag. A character with a parity error or a bad stop bit sets an error flag instead. A character that arrives while the data register is still full sets the overrun flag and is dropped.

Two interrupt outputs are provided. The receive interrupt is a one-cycle pulse for each good character. The error interrupt is a level that stays high until software clears it.

Software drives the register bus with plain write and read strobes, and has no back-pressure on it. Every access completes in the cycle it is issued. Read data is combinational from the address, and the side effect of a read takes place at the clock edge that ends that cycle. The full flag acts as the valid bit of the one-deep output stream, and reading the data register acts as the ready. The serial line cannot be stalled: a character that finds the data register occupied is lost and recorded as an overrun.

Register map (3-bit address):

| Address | Name | Bits |
|---|---|---|
| 0 | mode | bit0 = 7-bit characters, bit1 = parity enable, bit2 = odd parity (0 = even) |
| 1 | divisor | oversample tick every divisor+1 clocks |
| 2 | control | bit0 = receive enable, bit1 = interrupt enable |
| 3 | status | bit3 = parity error, bit4 = framing error, bit5 = overrun, bit6 = data full |
| 4 | data | received character (read only) |

Top module: `uart_rx_status`

## Requirements
- R1: After reset the registers read as follows: mode 0x00, divisor 0x07, control 0x00, status 0x00 and data 0x00. Both interrupt outputs are low.
- R2: While control bit0 is clear, line activity has no effect: status and data keep their values and no interrupt is raised.
- R3: A good character is written to the data register and sets status bit6. If control bit1 is set, rxi_o also pulses high for exactly one cycle; if it is clear, no pulse is produced.
- R4: Reading address 4 clears status bit6.
- R5: When a good character completes while status bit6 is set, the data register keeps its old value and status bit5 is set.
- R6: When mode bit1 is set, the bit after the data bits is parity. If the XOR of the data bits and the parity bit differs from mode bit2, status bit3 is set and the character is not stored.
- R7: A low stop-bit sample sets status bit4 and the character is not stored. A break (the line held low for longer than a frame) therefore sets bit4. After either event, the receiver waits for the line to return high before it looks for a new start bit.
- R8: When mode bit0 is set, each character has 7 data bits and bit 7 of the data register reads as zero.
- R9: If control bit1 is set when a parity, framing or overrun error occurs, eri_o goes high and stays high until one of the clear conditions of R11 occurs.
- R10: Writing status changes only bits 5 to 3. A bit is cleared only when it is written as 0 and the most recent status read saw that bit set. Writing 1 leaves the bit unchanged.
- R11: eri_o drops in two cases. The first is a status write where the most recent status read saw at least one error bit set and all three error bits end at zero. The second is a control write with bit1 clear.
- R12: Writes to mode and divisor are ignored while control bit0 is set.
- R13: A bit lasts 16*(divisor+1) clocks. Start detection, data bits (least significant first), parity and stop are taken from mid-bit samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| rxi_o | output | 1 | Receive interrupt, one-cycle pulse |
| eri_o | output | 1 | Error interrupt, level |

## Verification
Assertions check the following on every cycle:
- rxi_o is a single-cycle pulse, and it occurs only when interrupts were enabled.
- eri_o holds until a control or status write.
- An overrun leaves the data register unchanged.
- Reading the data register clears the full flag.
- Mode and divisor stay frozen while reception is enabled.
- No frame completes while reception is disabled.

Some behaviour can only be shown by the bench's serial scenarios, against its own model. This covers the timing and ordering of sampled bits, parity and framing decisions, 7-bit masking, break recovery, and the rule that an error bit clears only after a status read has seen it set.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    REG_MODE = 3'd0,
    REG_DIV  = 3'd1,
    REG_CTRL = 3'd2,
    REG_STAT = 3'd3,
    REG_DATA = 3'd4
  } reg_addr_e;

  localparam int MODE_SEVEN   = 0;
  localparam int MODE_PAR_EN  = 1;
  localparam int MODE_PAR_ODD = 2;
  localparam int CTRL_RX_EN   = 0;
  localparam int CTRL_IRQ_EN  = 1;
  localparam int STAT_ERR_LO  = 3;
  localparam int STAT_FULL    = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_WAIT_HIGH
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
  } rx_result_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d_i};
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R13: with a nonzero divisor, ticks are never on adjacent cycles
  p_tick_gap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       rx,
  input  logic       tick,
  input  logic       seven_bit,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       done_o,
  output rx_result_t res_o
);
  localparam int OS_W   = $clog2(OS_RATE);
  localparam int BIDX_W = $clog2(DATA_W);
  localparam logic [OS_W-1:0]   OS_MID  = OS_W'(OS_RATE / 2 - 1);
  localparam logic [OS_W-1:0]   OS_LAST = OS_W'(OS_RATE - 1);
  localparam logic [BIDX_W-1:0] IDX_FULL  = BIDX_W'(DATA_W - 1);
  localparam logic [BIDX_W-1:0] IDX_SHORT = BIDX_W'(DATA_W - 2);

  rx_state_e         state;
  logic [OS_W-1:0]   os_cnt;
  logic [BIDX_W-1:0] bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              par_acc;
  logic              mid_hit;

  assign mid_hit = tick && (os_cnt == OS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      os_cnt  <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
      done_o  <= 1'b0;
      res_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (!en) begin
        state  <= ST_IDLE;
        os_cnt <= '0;
      end else begin
        if (tick && state != ST_IDLE && state != ST_WAIT_HIGH) os_cnt <= os_cnt + 1'b1;
        case (state)
          ST_IDLE: begin
            os_cnt <= '0;
            if (tick && !rx) state <= ST_START;
          end
          ST_START: begin
            if (tick && os_cnt == OS_MID) begin
              os_cnt  <= '0;
              bit_idx <= '0;
              par_acc <= 1'b0;
              state   <= rx ? ST_IDLE : ST_DATA;
            end
          end
          ST_DATA: begin
            if (mid_hit) begin
              par_acc <= par_acc ^ rx;
              if (bit_idx == (seven_bit ? IDX_SHORT : IDX_FULL)) begin
                shreg <= seven_bit ? {1'b0, rx, shreg[DATA_W-1:2]} : {rx, shreg[DATA_W-1:1]};
                state <= par_en ? ST_PARITY : ST_STOP;
              end else begin
                shreg   <= {rx, shreg[DATA_W-1:1]};
                bit_idx <= bit_idx + 1'b1;
              end
            end
          end
          ST_PARITY: begin
            if (mid_hit) begin
              par_acc <= par_acc ^ rx;
              state   <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (mid_hit) begin
              done_o     <= 1'b1;
              res_o.data <= shreg;
              res_o.perr <= par_en & (par_acc ^ par_odd);
              res_o.ferr <= ~rx;
              state      <= rx ? ST_IDLE : ST_WAIT_HIGH;
            end
          end
          ST_WAIT_HIGH: begin
            if (rx) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: a completed frame is reported for one cycle only
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R2: nothing completes while reception is disabled
  p_no_done_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !done_o);
  // R8: a 7-bit character never carries a top bit
  p_seven_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_hit && state == ST_STOP && seven_bit) |=> !res_o.data[DATA_W-1]);
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
#(
  parameter int              DIV_W     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = 8'd7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             done_i,
  input  rx_result_t       res_i,
  output logic             rx_en,
  output logic             seven_bit,
  output logic             par_en,
  output logic             par_odd,
  output logic [DIV_W-1:0] div,
  output logic             rxi_o,
  output logic             eri_o
);
  logic [2:0]       mode_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       ctrl_q;
  logic [2:0]       err_q, err_n;     // {overrun, framing, parity}
  logic [2:0]       seen_q, seen_n;
  logic             full_q, full_n;
  logic [7:0]       data_q, data_n;
  logic             eri_n, rxi_n;
  logic             irq_en;

  assign irq_en = ctrl_q[CTRL_IRQ_EN];

  always_comb begin
    err_n  = err_q;
    seen_n = seen_q;
    full_n = full_q;
    data_n = data_q;
    eri_n  = eri_o;
    rxi_n  = 1'b0;
    if (rd_en && addr == REG_STAT) seen_n = err_q;
    if (rd_en && addr == REG_DATA) full_n = 1'b0;
    if (wr_en && addr == REG_STAT) begin
      err_n = err_q & (wdata[STAT_ERR_LO+2:STAT_ERR_LO] | ~seen_q);
      if (seen_q != 3'b000 && err_n == 3'b000) eri_n = 1'b0;
    end
    if (wr_en && addr == REG_CTRL && !wdata[CTRL_IRQ_EN]) eri_n = 1'b0;
    if (done_i) begin
      if (res_i.perr || res_i.ferr) begin
        err_n[0] = err_n[0] | res_i.perr;
        err_n[1] = err_n[1] | res_i.ferr;
        if (irq_en) eri_n = 1'b1;
      end else if (full_q) begin
        err_n[2] = 1'b1;
        if (irq_en) eri_n = 1'b1;
      end else begin
        data_n = res_i.data;
        full_n = 1'b1;
        rxi_n  = irq_en;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      div_q  <= DIV_RESET;
      ctrl_q <= '0;
      err_q  <= '0;
      seen_q <= '0;
      full_q <= 1'b0;
      data_q <= '0;
      eri_o  <= 1'b0;
      rxi_o  <= 1'b0;
    end else begin
      if (wr_en && !rx_en && addr == REG_MODE) mode_q <= wdata[2:0];
      if (wr_en && !rx_en && addr == REG_DIV)  div_q  <= wdata[DIV_W-1:0];
      if (wr_en && addr == REG_CTRL)           ctrl_q <= wdata[1:0];
      err_q  <= err_n;
      seen_q <= seen_n;
      full_q <= full_n;
      data_q <= data_n;
      eri_o  <= eri_n;
      rxi_o  <= rxi_n;
    end
  end

  always_comb begin
    case (addr)
      REG_MODE: rdata = {5'b0, mode_q};
      REG_DIV:  rdata = 8'(div_q);
      REG_CTRL: rdata = {6'b0, ctrl_q};
      REG_STAT: rdata = {1'b0, full_q, err_q, 3'b000};
      REG_DATA: rdata = data_q;
      default:  rdata = 8'h00;
    endcase
  end

  assign rx_en     = ctrl_q[CTRL_RX_EN];
  assign seven_bit = mode_q[MODE_SEVEN];
  assign par_en    = mode_q[MODE_PAR_EN];
  assign par_odd   = mode_q[MODE_PAR_ODD];
  assign div       = div_q;

  // R3: the receive pulse lasts one cycle and needs the enable
  p_rxi_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rxi_o |=> !rxi_o);
  p_rxi_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rxi_o |-> $past(irq_en));
  // R4: a data read empties the register unless a new character lands
  p_full_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == REG_DATA && !done_i) |=> !full_q);
  // R5: overrun keeps the stored character and flags it
  p_overrun_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !res_i.perr && !res_i.ferr && full_q) |=> (data_q == $past(data_q) && err_q[2]));
  // R9: the error level holds unless software writes control or status
  p_eri_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eri_o && !(wr_en && (addr == REG_CTRL || addr == REG_STAT))) |=> eri_o);
  p_err_raises_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && (res_i.perr || res_i.ferr) && irq_en) |=> eri_o);
  // R12: configuration is frozen while receiving
  p_cfg_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |=> ($stable(mode_q) && $stable(div_q)));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int               DIV_W       = 8,
  parameter logic [DIV_W-1:0] DIV_RESET   = 8'd7,
  parameter int               OS_RATE     = 16,
  parameter int               SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  input  logic       reg_wr_en,
  input  logic       reg_rd_en,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       rxi_o,
  output logic       eri_o
);
  logic             rx_s, tick, done;
  logic             rx_en, seven_bit, par_en, par_odd;
  logic [DIV_W-1:0] div;
  rx_result_t       res;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
  );

  uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .div(div), .tick(tick)
  );

  uart_rx_frame #(.DATA_W(8), .OS_RATE(OS_RATE)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .rx(rx_s), .tick(tick),
    .seven_bit(seven_bit), .par_en(par_en), .par_odd(par_odd),
    .done_o(done), .res_o(res)
  );

  uart_rx_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .done_i(done), .res_i(res), .rx_en(rx_en), .seven_bit(seven_bit),
    .par_en(par_en), .par_odd(par_odd), .div(div),
    .rxi_o(rxi_o), .eri_o(eri_o)
  );
endmodule

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       rxi, eri;

  int checks = 0, errors = 0, rxi_seen = 0;
  bit busy = 1'b1, rxi_prev = 1'b0;

  // reference model state
  logic [2:0] m_mode, m_err, m_seen;
  logic [7:0] m_div, m_data;
  logic [1:0] m_ctrl;
  logic       m_full, m_eri;
  int         m_rxi;

  always #4 clk = ~clk;

  uart_rx_status dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .rxi_o(rxi), .eri_o(eri)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // R9 eri level compared with the model on every quiet clock
  always @(negedge clk) begin
    if (rst_n && !busy) check(eri == m_eri, "R9/R11 eri level", {7'b0, eri}, {7'b0, m_eri});
  end

  // R3 pulse width monitor
  always @(negedge clk) begin
    if (rxi) begin
      rxi_seen++;
      if (rxi_prev) check(1'b0, "R3 rxi wider than one cycle", 8'd1, 8'd0);
    end
    rxi_prev = rxi;
  end

  function automatic logic [7:0] exp_stat();
    return {1'b0, m_full, m_err, 3'b000};
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    logic [2:0] nerr;
    busy = 1'b1;
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    case (a)
      3'd0: if (!m_ctrl[0]) m_mode = d[2:0];
      3'd1: if (!m_ctrl[0]) m_div = d;
      3'd2: begin m_ctrl = d[1:0]; if (!d[1]) m_eri = 1'b0; end
      3'd3: begin
        nerr = m_err & (d[5:3] | ~m_seen);
        if (m_seen != 3'b000 && nerr == 3'b000) m_eri = 1'b0;
        m_err = nerr;
      end
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
    busy = 1'b0;
  endtask

  task automatic read_expect(input logic [2:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    busy = 1'b1;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    check(v == exp, tag, v, exp);
    if (a == 3'd3) m_seen = m_err;
    if (a == 3'd4) m_full = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
    busy = 1'b0;
  endtask

  task automatic model_frame(input logic [7:0] recv, input bit perr, input bit ferr);
    if (!m_ctrl[0]) return;
    if (perr || ferr) begin
      if (perr) m_err[0] = 1'b1;
      if (ferr) m_err[1] = 1'b1;
      if (m_ctrl[1]) m_eri = 1'b1;
    end else if (m_full) begin
      m_err[2] = 1'b1;
      if (m_ctrl[1]) m_eri = 1'b1;
    end else begin
      m_data = recv;
      m_full = 1'b1;
      if (m_ctrl[1]) m_rxi++;
    end
  endtask

  task automatic drive_bit(input logic v);
    int len = 16 * (int'(m_div) + 1);
    @(negedge clk);
    rx = v;
    repeat (len - 1) @(negedge clk);
  endtask

  // par_flip inverts the correct parity bit for the current mode
  task automatic send_frame(input logic [7:0] d, input bit par_flip, input logic stop_bit);
    int nbits = m_mode[0] ? 7 : 8;
    logic [7:0] recv = m_mode[0] ? (d & 8'h7F) : d;
    logic par_bit = (^recv) ^ m_mode[2] ^ par_flip;
    busy = 1'b1;
    drive_bit(1'b0);
    for (int i = 0; i < nbits; i++) drive_bit(d[i]);
    if (m_mode[1]) drive_bit(par_bit);
    drive_bit(stop_bit);
    @(negedge clk);
    rx = 1'b1;
    repeat (2 * 16 * (int'(m_div) + 1)) @(negedge clk);
    model_frame(recv, m_mode[1] && par_flip, !stop_bit);
    busy = 1'b0;
  endtask

  task automatic send_break(input int nbits_low);
    busy = 1'b1;
    for (int i = 0; i < nbits_low; i++) drive_bit(1'b0);
    @(negedge clk);
    rx = 1'b1;
    repeat (2 * 16 * (int'(m_div) + 1)) @(negedge clk);
    model_frame(8'h00, m_mode[1] && m_mode[2], 1'b1);
    busy = 1'b0;
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    finish_sim();
  end

  initial begin
    m_mode = '0; m_err = '0; m_seen = '0; m_div = 8'd7; m_data = '0;
    m_ctrl = '0; m_full = 1'b0; m_eri = 1'b0; m_rxi = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    busy = 1'b0;

    // R1 reset state
    read_expect(3'd0, 8'h00, "R1 mode reset");
    read_expect(3'd1, 8'h07, "R1 divisor reset");
    read_expect(3'd2, 8'h00, "R1 control reset");
    read_expect(3'd3, 8'h00, "R1 status reset");
    read_expect(3'd4, 8'h00, "R1 data reset");
    check(rxi == 1'b0, "R1 rxi reset", {7'b0, rxi}, 8'h00);

    // R2 disabled receiver ignores the line
    send_frame(8'h5A, 1'b0, 1'b1);
    read_expect(3'd3, 8'h00, "R2 status unchanged while disabled");
    read_expect(3'd4, 8'h00, "R2 data unchanged while disabled");

    reg_write(3'd1, 8'd1);
    reg_write(3'd2, 8'h03);
    // R12 config locked while enabled
    reg_write(3'd0, 8'h07);
    reg_write(3'd1, 8'd5);
    read_expect(3'd0, 8'h00, "R12 mode write ignored");
    read_expect(3'd1, 8'h01, "R12 divisor write ignored");

    // R3 / R13 good character, LSB first
    send_frame(8'hA5, 1'b0, 1'b1);
    check(rxi_seen == m_rxi, "R3 rxi pulse count", 8'(rxi_seen), 8'(m_rxi));
    read_expect(3'd3, 8'h40, "R3 full flag set");
    read_expect(3'd4, 8'hA5, "R13 received byte");
    read_expect(3'd3, 8'h00, "R4 full cleared by data read");

    // R5 overrun
    send_frame(8'h3C, 1'b0, 1'b1);
    send_frame(8'h81, 1'b0, 1'b1);
    check(eri == 1'b1, "R9 eri after overrun", {7'b0, eri}, 8'h01);

    // R10 clearing needs a status read that saw the bit
    reg_write(3'd3, 8'h00);
    read_expect(3'd3, 8'h60, "R10 unseen overrun not cleared");
    reg_write(3'd3, 8'h20);
    read_expect(3'd3, 8'h60, "R10 writing one keeps overrun");
    reg_write(3'd3, 8'h00);
    check(eri == 1'b0, "R11 eri dropped by status clear", {7'b0, eri}, 8'h00);
    read_expect(3'd3, 8'h40, "R10 overrun cleared");
    read_expect(3'd4, 8'h3C, "R5 data kept on overrun");

    // R6 parity, even then odd
    reg_write(3'd2, 8'h00);
    reg_write(3'd0, 8'h02);
    reg_write(3'd2, 8'h03);
    send_frame(8'h07, 1'b0, 1'b1);
    read_expect(3'd4, 8'h07, "R6 even parity good");
    send_frame(8'h07, 1'b1, 1'b1);
    read_expect(3'd3, exp_stat(), "R6 even parity error flag");
    check(eri == 1'b1, "R9 eri after parity error", {7'b0, eri}, 8'h01);
    reg_write(3'd3, 8'h00);
    reg_write(3'd2, 8'h00);
    reg_write(3'd0, 8'h06);
    reg_write(3'd2, 8'h03);
    send_frame(8'hC3, 1'b0, 1'b1);
    read_expect(3'd3, 8'h40, "R6 odd parity good");
    read_expect(3'd4, 8'hC3, "R6 odd parity data");
    send_frame(8'hC3, 1'b1, 1'b1);
    read_expect(3'd3, 8'h08, "R6 odd parity error flag");
    reg_write(3'd3, 8'h00);

    // R7 framing error, then R11 control write drops eri
    reg_write(3'd2, 8'h00);
    reg_write(3'd0, 8'h00);
    reg_write(3'd2, 8'h03);
    send_frame(8'h99, 1'b0, 1'b0);
    read_expect(3'd3, 8'h10, "R7 framing error flag");
    check(eri == 1'b1, "R9 eri after framing error", {7'b0, eri}, 8'h01);
    reg_write(3'd2, 8'h01);
    check(eri == 1'b0, "R11 eri dropped by control write", {7'b0, eri}, 8'h00);
    reg_write(3'd3, 8'h00);

    // R3 no pulse with interrupts disabled
    send_frame(8'h4E, 1'b0, 1'b1);
    check(rxi_seen == m_rxi, "R3 no pulse when disabled", 8'(rxi_seen), 8'(m_rxi));
    read_expect(3'd4, 8'h4E, "R3 data with irq off");

    // R7 break then a clean character
    send_break(14);
    read_expect(3'd3, 8'h10, "R7 break sets framing");
    send_frame(8'hE1, 1'b0, 1'b1);
    read_expect(3'd4, 8'hE1, "R7 receiver recovers after break");
    reg_write(3'd3, 8'h00);
    read_expect(3'd3, 8'h00, "R10 framing cleared after seen");

    // R8 seven-bit characters
    reg_write(3'd2, 8'h00);
    reg_write(3'd0, 8'h01);
    reg_write(3'd2, 8'h03);
    send_frame(8'hEA, 1'b0, 1'b1);
    read_expect(3'd4, 8'h6A, "R8 seven-bit data top bit zero");
    check(rxi_seen == m_rxi, "R3 rxi pulse count final", 8'(rxi_seen), 8'(m_rxi));

    // R2 disabling again freezes status
    reg_write(3'd2, 8'h00);
    send_frame(8'h11, 1'b0, 1'b1);
    read_expect(3'd3, 8'h00, "R2 status frozen while disabled");
    read_expect(3'd4, 8'h6A, "R2 data frozen while disabled");

    finish_sim();
  end
endmodule